// File: doc/BRIEF.md
# Set/Clear Aliased Status Register

This block holds one 64-bit control and status word behind a simple request/response register bus. Software reaches the word at a direct offset, where a write replaces the stored value, or at two alias offsets that combine the write data with the current contents before storing. Only the top sixteen bits of the word are kept; the lower 48 bits are always zero. The most significant bit drives a level interrupt output. The interrupt has no acknowledge of its own, so any route that clears that bit also drops the interrupt.

A compile-time parameter selects one of two variants. They differ in the offsets they decode and in what the second alias does. In the first variant that alias ANDs the write data into the word. In the second variant it zeroes the word whatever the write data holds. Accesses that hit no implemented register, that are not a full aligned 8-byte access, or that read an alias offset return zero and raise a one-cycle "unmapped" flag.

Top module: `srs_alias_reg`

## Requirements
- R1: After reset the stored word is zero, irq_o is 0, rsp_valid_o is 0 and unmapped_o is 0.
- R2: A full write at the direct offset stores wdata with bits 47..0 forced to zero; a read of the direct offset never shows a nonzero bit below bit 48.
- R3: A write at the OR alias stores (current | wdata) masked to bits 63..48.
- R4: With VARIANT 0, a write at the AND alias stores (current & wdata) masked to bits 63..48.
- R5: With VARIANT 1, a write at the clear alias sets the whole word to zero for any wdata.
- R6: irq_o changes on the same clock edge that updates the word and then equals bit 63 of the new value.
- R7: A read request at the direct offset returns the stored word on rsp_rdata_o with rsp_valid_o high for exactly the cycle after the request edge; a write produces no response.
- R8: A read at any other offset, including both alias offsets, returns zero with rsp_valid_o high, and raises unmapped_o.
- R9: A write at an unimplemented offset leaves the word unchanged and raises unmapped_o for one cycle.
- R10: An access with a byte count other than 8 or a byte address whose bits 2..0 are not zero is unmapped: it changes nothing, a read returns zero, and unmapped_o rises.
- R11: The word offset is the byte address shifted right by 3. VARIANT 0 decodes 0x4020 direct, 0x4021 AND, 0x4022 OR; VARIANT 1 decodes 0x6080 direct, 0x6081 clear, 0x6082 OR; the other variant's offsets are unmapped.
- R12: req_ready_o is 1 at all times after reset, and unmapped_o is 0 in the cycle after a mapped access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_bytes_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Read response valid, one cycle after the request |
| rsp_rdata_o | output | 64 | Read response data |
| unmapped_o | output | 1 | One-cycle pulse after an access to no implemented register |
| irq_o | output | 1 | Level interrupt, mirrors bit 63 of the word |

## Verification
The bench builds one instance of each variant and drives each alias with data that separates AND, OR, replace and clear. A wrong merge then leaves a value other than the expected one in bits 63..48. It writes data with every low bit set to catch a mask applied before the merge or not at all, and it toggles bit 63 through each route to catch an interrupt that lags a cycle or that ignores the clear alias. It reads the alias offsets and sends writes to the other variant's offsets, with short and misaligned accesses, to catch a decoder that lets those reach the word or that leaves the unmapped flag low.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned DataW = 64;
  localparam int unsigned BytesW = 4;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_CLEAR = 3'd4
  } srs_op_e;

  function automatic int unsigned base_word(int unsigned variant);
    return (variant == 0) ? 32'h4020 : 32'h6080;
  endfunction
endpackage

// File: rtl/srs_decode.sv
module srs_decode
  import srs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned VARIANT = 0
) (
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BytesW-1:0] bytes_i,
  output srs_op_e           op_o,
  output logic              rd_hit_o,
  output logic              bad_o
);
  localparam int unsigned BYTE_SH = $clog2(DATA_W / 8);
  localparam int unsigned WORD_W  = ADDR_W - BYTE_SH;
  localparam logic [WORD_W-1:0] OFF_DIRECT = WORD_W'(base_word(VARIANT));
  localparam logic [WORD_W-1:0] OFF_ALIAS2 = WORD_W'(base_word(VARIANT) + 1);
  localparam logic [WORD_W-1:0] OFF_OR     = WORD_W'(base_word(VARIANT) + 2);
  localparam srs_op_e ALIAS2_OP = (VARIANT == 0) ? OP_AND : OP_CLEAR;

  logic [WORD_W-1:0] word;
  logic              shape_ok;

  assign word     = addr_i[ADDR_W-1:BYTE_SH];
  assign shape_ok = (bytes_i == BytesW'(DATA_W / 8)) &&
                    (addr_i[BYTE_SH-1:0] == '0);

  always_comb begin
    op_o     = OP_NONE;
    rd_hit_o = 1'b0;
    bad_o    = 1'b0;
    if (valid_i) begin
      if (!shape_ok) begin
        bad_o = 1'b1;
      end else if (we_i) begin
        unique case (word)
          OFF_DIRECT: op_o = OP_WRITE;
          OFF_ALIAS2: op_o = ALIAS2_OP;
          OFF_OR:     op_o = OP_OR;
          default:    bad_o = 1'b1;
        endcase
      end else if (word == OFF_DIRECT) begin
        rd_hit_o = 1'b1;
      end else begin
        bad_o = 1'b1;
      end
    end
  end

  // r10/r11: a rejected access never carries an operation
  always_comb begin
    a_r11_bad_no_op: assert (!(bad_o && (op_o != OP_NONE || rd_hit_o)));
  end
endmodule

// File: rtl/srs_merge.sv
module srs_merge
  import srs_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 16
) (
  input  srs_op_e           op_i,
  input  logic [DATA_W-1:0] cur_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              upd_o,
  output logic [DATA_W-1:0] nxt_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{KEEP_W{1'b1}}, {(DATA_W - KEEP_W){1'b0}}};

  logic [DATA_W-1:0] raw;

  always_comb begin
    upd_o = 1'b1;
    unique case (op_i)
      OP_WRITE: raw = wdata_i;
      OP_AND:   raw = cur_i & wdata_i;
      OP_OR:    raw = cur_i | wdata_i;
      OP_CLEAR: raw = '0;
      default: begin
        raw   = cur_i;
        upd_o = 1'b0;
      end
    endcase
    nxt_o = raw & KEEP_MASK;  // mask after merge
  end
endmodule

// File: rtl/srs_store.sv
module srs_store #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned KEEP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [DATA_W-1:0] nxt_i,
  output logic [DATA_W-1:0] val_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] val_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      irq_q <= 1'b0;
    end else if (upd_i) begin
      val_q <= nxt_i;
      irq_q <= nxt_i[DATA_W-1];
    end
  end

  assign val_o = val_q;
  assign irq_o = irq_q;

  a_r2_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q[DATA_W-KEEP_W-1:0] == '0);

  a_r6_irq_same_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> irq_q == $past(nxt_i[DATA_W-1]));

  a_r6_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(irq_q));
endmodule

// File: rtl/srs_alias_reg.sv
module srs_alias_reg
  import srs_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned KEEP_W  = 16,
  parameter int unsigned VARIANT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BytesW-1:0] req_bytes_i,
  input  logic [DataW-1:0]  req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DataW-1:0]  rsp_rdata_o,
  output logic              unmapped_o,
  output logic              irq_o
);
  srs_op_e          op;
  logic             rd_hit, bad, upd;
  logic [DataW-1:0] cur, nxt;
  logic             rsp_valid_q, unmapped_q;
  logic [DataW-1:0] rsp_rdata_q;

  srs_decode #(.ADDR_W(ADDR_W), .DATA_W(DataW), .VARIANT(VARIANT)) i_decode (
    .valid_i (req_valid_i),
    .we_i    (req_we_i),
    .addr_i  (req_addr_i),
    .bytes_i (req_bytes_i),
    .op_o    (op),
    .rd_hit_o(rd_hit),
    .bad_o   (bad)
  );

  srs_merge #(.DATA_W(DataW), .KEEP_W(KEEP_W)) i_merge (
    .op_i   (op),
    .cur_i  (cur),
    .wdata_i(req_wdata_i),
    .upd_o  (upd),
    .nxt_o  (nxt)
  );

  srs_store #(.DATA_W(DataW), .KEEP_W(KEEP_W)) i_store (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (upd),
    .nxt_i (nxt),
    .val_o (cur),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      unmapped_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_we_i;
      rsp_rdata_q <= rd_hit ? cur : '0;
      unmapped_q  <= bad;
    end
  end

  assign req_ready_o = 1'b1;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign unmapped_o  = unmapped_q;

  a_r9_unmapped_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && bad) |=> $stable(cur));

  a_r9_unmapped_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && bad) |=> unmapped_o);

  a_r8_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i && bad) |=> (rsp_valid_o && rsp_rdata_o == '0));

  a_r7_no_rsp_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i || req_we_i) |=> !rsp_valid_o);

  a_r12_clean_after_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !bad) |=> !unmapped_o);

  generate
    if (VARIANT != 0) begin : g_clear
      a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_CLEAR) |=> (cur == '0 && !irq_o));
    end
  endgenerate
endmodule

// File: tb/test_srs_alias_reg.sv
module test_srs_alias_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic        v_a, we_a, v_b, we_b;
  logic [19:0] ad_a, ad_b;
  logic [3:0]  by_a, by_b;
  logic [63:0] wd_a, wd_b;
  logic        rdy_a, rv_a, un_a, irq_a, rdy_b, rv_b, un_b, irq_b;
  logic [63:0] rd_a, rd_b;

  logic        g_rv, g_un, g_irq;
  logic [63:0] g_rd;

  localparam logic [19:0] A_DIR = 20'h20100, A_AND = 20'h20108, A_OR = 20'h20110;
  localparam logic [19:0] B_DIR = 20'h30400, B_CLR = 20'h30408, B_OR = 20'h30410;

  srs_alias_reg #(.VARIANT(0)) i_srs_alias_reg (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v_a), .req_ready_o(rdy_a),
    .req_we_i(we_a), .req_addr_i(ad_a), .req_bytes_i(by_a), .req_wdata_i(wd_a),
    .rsp_valid_o(rv_a), .rsp_rdata_o(rd_a), .unmapped_o(un_a), .irq_o(irq_a));

  srs_alias_reg #(.VARIANT(1)) i_srs_alias_reg_b (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v_b), .req_ready_o(rdy_b),
    .req_we_i(we_b), .req_addr_i(ad_b), .req_bytes_i(by_b), .req_wdata_i(wd_b),
    .rsp_valid_o(rv_b), .rsp_rdata_o(rd_b), .unmapped_o(un_b), .irq_o(irq_b));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one access; outputs captured one cycle after the request edge
  task automatic acc(input bit sel, input bit we, input logic [19:0] ad,
                     input logic [63:0] wd, input logic [3:0] by = 4'd8);
    @(negedge clk);
    if (!sel) begin v_a = 1; we_a = we; ad_a = ad; wd_a = wd; by_a = by; end
    else      begin v_b = 1; we_b = we; ad_b = ad; wd_b = wd; by_b = by; end
    @(negedge clk);
    v_a = 0; v_b = 0;
    if (!sel) begin g_rv = rv_a; g_rd = rd_a; g_un = un_a; g_irq = irq_a; end
    else      begin g_rv = rv_b; g_rd = rd_b; g_un = un_b; g_irq = irq_b; end
  endtask

  task automatic rd_dir(input bit sel, output logic [63:0] val);
    acc(sel, 0, sel ? B_DIR : A_DIR, '0);
    val = g_rd;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    chk("R1 irq a", 64'(irq_a), 0);
    chk("R1 irq b", 64'(irq_b), 0);
    chk("R1 rsp_valid", 64'(rv_a | rv_b), 0);
    chk("R1 unmapped", 64'(un_a | un_b), 0);
    chk("R12 ready", 64'(rdy_a & rdy_b), 1);
    rd_dir(0, v);
    chk("R1 word a", v, 0);
    chk("R7 rsp_valid on read", 64'(g_rv), 1);
    chk("R12 no unmapped after hit", 64'(g_un), 0);
  endtask

  task automatic t_variant_a;
    logic [63:0] v;
    acc(0, 1, A_DIR, 64'hDEAD_BEEF_1234_5678);
    chk("R6 irq set same edge", 64'(g_irq), 1);
    chk("R7 no rsp on write", 64'(g_rv), 0);
    rd_dir(0, v);
    chk("R2 direct masked", v, 64'hDEAD_0000_0000_0000);
    acc(0, 1, A_AND, 64'h00FF_FFFF_FFFF_FFFF);
    chk("R6 irq cleared by and", 64'(g_irq), 0);
    rd_dir(0, v);
    chk("R4 and merge", v, 64'h00AD_0000_0000_0000);
    acc(0, 1, A_OR, 64'h8100_0000_0000_0001);
    chk("R6 irq set by or", 64'(g_irq), 1);
    rd_dir(0, v);
    chk("R3 or merge", v, 64'h81AD_0000_0000_0000);
    acc(0, 1, A_DIR, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R6 irq cleared by direct", 64'(g_irq), 0);
    rd_dir(0, v);
    chk("R2 low bits zero", v, 64'h7FFF_0000_0000_0000);
  endtask

  task automatic t_unmapped_a;
    logic [63:0] v;
    acc(0, 0, A_AND, '0);
    chk("R8 alias read zero", g_rd, 0);
    chk("R8 alias read valid", 64'(g_rv), 1);
    chk("R8 alias read unmapped", 64'(g_un), 1);
    acc(0, 0, A_OR, '0);
    chk("R8 or alias read zero", g_rd, 0);
    acc(0, 1, 20'h20118, '0);
    chk("R9 unmapped write flag", 64'(g_un), 1);
    @(negedge clk);
    chk("R9 flag one cycle", 64'(un_a), 0);
    acc(0, 1, B_CLR, '0);
    chk("R11 other variant offset unmapped", 64'(g_un), 1);
    acc(0, 1, A_DIR, '0, 4'd4);
    chk("R10 short write unmapped", 64'(g_un), 1);
    acc(0, 1, A_DIR | 20'h4, '0);
    chk("R10 misaligned write unmapped", 64'(g_un), 1);
    acc(0, 0, A_DIR, '0, 4'd4);
    chk("R10 short read zero", g_rd, 0);
    rd_dir(0, v);
    chk("R9 word unchanged", v, 64'h7FFF_0000_0000_0000);
  endtask

  task automatic t_variant_b;
    logic [63:0] v;
    acc(1, 1, B_DIR, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 b irq set", 64'(g_irq), 1);
    acc(1, 1, B_CLR, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5 clear drops irq", 64'(g_irq), 0);
    rd_dir(1, v);
    chk("R5 clear zeroes", v, 0);
    acc(1, 1, B_OR, 64'h0012_0000_0000_00FF);
    acc(1, 1, B_OR, 64'h8001_0000_0000_0000);
    rd_dir(1, v);
    chk("R3 b or merge", v, 64'h8013_0000_0000_0000);
    chk("R11 b direct read", 64'(g_un), 0);
    acc(1, 1, A_DIR, '0);
    chk("R11 b rejects a offset", 64'(g_un), 1);
    rd_dir(1, v);
    chk("R11 b word kept", v, 64'h8013_0000_0000_0000);
    chk("R6 b irq kept", 64'(irq_b), 1);
  endtask

  initial begin
    v_a = 0; we_a = 0; ad_a = '0; by_a = 4'd8; wd_a = '0;
    v_b = 0; we_b = 0; ad_b = '0; by_b = 4'd8; wd_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_variant_a();
    t_unmapped_a();
    t_variant_b();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule